// File: doc/BRIEF.md
# Two-Half Count-Up Timer with Compare Bank

This block is a timer peripheral built around a counter space that is split into a lower and an upper 32-bit half. In the mode the block implements, the halves run as two unchained timers. Each half has its own counter, its own period register and its own enable-mode field. The enable field selects one of three behaviours: stopped, single shot or repeating. A period match on a half raises that half's interrupt. A global control register selects the timer mode and holds one run bit per half. While a run bit is low, that half is pinned in reset.

The lower counter also feeds a bank of compare registers. When the lower counter steps onto a value held in any compare entry, the block raises a compare interrupt that is separate from the period interrupts. With this, one free-running counter can serve as the time base and as a single-shot event source at the same time.

Software reaches every register through a plain word-addressed bus: address, write strobe, write data, and read data that is registered one cycle after the address. A counter can be written directly, for example to clear it before a new period is loaded.

Top module: `dual_timer`

## Requirements
- R1: After the synchronous reset, all registers read 0 and the three interrupt outputs are low.
- R2: The register map uses word addresses. Address 0 is the control register: the lower half's enable field sits at bits 7:6 and the upper half's at bits 23:22, and every other bit reads 0. Address 1 is the global register, and only bits 3:0 are kept. Addresses 2 and 3 are the lower and upper counters. Addresses 4 and 5 are the lower and upper periods. Addresses 8+k are compare entry k. Unused addresses read 0. Read data appears in the cycle after the address is presented.
- R3: A half counts up by one each clock when all three of these hold: its run bit is 1, the global timer-mode field (bits 3:2) is 1 (unchained), and its enable field is 1 or 2. Its count wraps from 2^32-1 to 0.
- R4: Global bit 0 (lower) and bit 1 (upper) are run bits. While a run bit is 0, that half's counter is forced to 0, and writes to that counter have no effect.
- R5: Enable code 2 (repeating). When a running half's counter equals its period, the half's interrupt goes high for one cycle and the counter restarts from 0, so interrupts come every period+1 clocks.
- R6: Enable code 1 (single shot). When the counter reaches the period, the interrupt pulses once, the half's enable field returns to 0, and the counter stays at the period value.
- R7: Enable codes 0 and 3 stop the half, and its counter keeps its value.
- R8: Global timer-mode codes 0, 2 and 3 (the 64-bit and chained modes) stop both halves, and their counters keep their values.
- R9: A bus write to a counter of a half that is out of reset loads that value on the next clock, and it takes priority over counting.
- R10: In the cycle in which the lower counter changes to a value equal to any of the eight compare entries, the compare interrupt is high. It is registered, so it is high while the counter shows that value.
- R11: A compare entry fires only when the counter changes onto its value. An entry loaded with a value the counter has already passed, or with the value the stopped counter is holding, stays silent.
- R12: The upper half works on its own, with its enable field at bits 23:22 and its own interrupt. It leaves the lower half untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_lo | output | 1 | Lower-half period interrupt, one-cycle pulse |
| irq_hi | output | 1 | Upper-half period interrupt, one-cycle pulse |
| irq_cmp | output | 1 | Compare-match interrupt from the lower counter |

## Verification
The bound checker watches the following on every cycle: the single-step increment of a running half, the zero forced by a cleared run bit, the freeze under a stopped enable field or a foreign timer mode, the restart from zero together with the interrupt in repeating mode, the self-clearing enable field after a single shot, and the rule that a compare interrupt always comes with a changed counter. Only the directed scenarios can show the absolute spacing of the interrupts, the wrap through 2^32-1, the register map and its read latency, the silence of a compare entry that was loaded late, and the independence of the two halves.

// File: rtl/dt_pkg.sv
package dt_pkg;

  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_LOOP = 2'd2,
    EN_RSVD = 2'd3
  } en_mode_t;

  localparam logic [1:0] TM_GP64   = 2'd0;
  localparam logic [1:0] TM_UNCH32 = 2'd1;
  localparam logic [1:0] TM_WD64   = 2'd2;
  localparam logic [1:0] TM_CHN32  = 2'd3;

  localparam int LO_EN_LSB = 6;
  localparam int HI_EN_LSB = 22;
  localparam int GCTL_BITS = 4;

endpackage

// File: rtl/dt_half.sv
module dt_half
  import dt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         out_of_rst,
  input  logic         count_ok,
  input  en_mode_t     mode,
  input  logic         cnt_we,
  input  logic         prd_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] prd_q,
  output logic [W-1:0] cnt_d,
  output logic         irq_q,
  output logic         once_done
);

  logic hit;
  logic live;
  logic irq_d;

  always_comb begin
    hit       = (cnt_q == prd_q);
    live      = count_ok && (mode == EN_ONCE || mode == EN_LOOP);
    cnt_d     = cnt_q;
    irq_d     = 1'b0;
    once_done = 1'b0;
    if (!out_of_rst) begin
      cnt_d = '0;
    end else if (cnt_we) begin
      cnt_d = wdata;
    end else if (live) begin
      if (hit) begin
        irq_d = 1'b1;
        if (mode == EN_LOOP) cnt_d = '0;
        else                 once_done = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      prd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      if (prd_we) prd_q <= wdata;
    end
  end

endmodule

// File: rtl/dt_cmp_bank.sv
module dt_cmp_bank #(
  parameter int W  = 32,
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  input  logic [W-1:0]  cnt_q,
  input  logic [W-1:0]  cnt_d,
  output logic [W-1:0]  rd_val,
  output logic          irq_q
);

  logic [W-1:0] cmp_q [N];
  logic [N-1:0] hit;

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                           cmp_q[k] <= '0;
      else if (we && widx == IW'(k))     cmp_q[k] <= wdata;
    end
    assign hit[k] = (cnt_d == cmp_q[k]);
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N; k++)
      if (ridx == IW'(k)) rd_val = cmp_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (cnt_d != cnt_q) && (|hit);
  end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dt_pkg::*;
#(
  parameter int W    = 32,
  parameter int NCMP = 8,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          irq_cmp
);

  localparam int IW = (NCMP > 1) ? $clog2(NCMP) : 1;
  localparam logic [AW-1:0] A_CTRL   = AW'(0);
  localparam logic [AW-1:0] A_GCTL   = AW'(1);
  localparam logic [AW-1:0] A_CNT0   = AW'(2);
  localparam logic [AW-1:0] A_PRD0   = AW'(4);
  localparam logic [AW-1:0] A_CMP0   = AW'(8);
  localparam logic [AW-1:0] A_CMPEND = AW'(8 + NCMP - 1);

  en_mode_t                 mode_q [2];
  logic [GCTL_BITS-1:0]     gctl_q;
  logic [W-1:0]             cnt_q  [2];
  logic [W-1:0]             prd_q  [2];
  logic [W-1:0]             cnt_d  [2];
  logic [1:0]               irq_h;
  logic [1:0]               once_done;
  logic [1:0]               wr_cnt;
  logic [1:0]               wr_prd;
  logic                     wr_ctrl;
  logic                     wr_gctl;
  logic                     in_cmp;
  logic [IW-1:0]            cmp_idx;
  logic [W-1:0]             cmp_rd;
  logic [W-1:0]             ctrl_view;
  logic                     count_ok;

  always_comb begin
    wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    wr_gctl  = bus_we && (bus_addr == A_GCTL);
    in_cmp   = (bus_addr >= A_CMP0) && (bus_addr <= A_CMPEND);
    cmp_idx  = IW'(bus_addr - A_CMP0);
    count_ok = (gctl_q[3:2] == TM_UNCH32);
    for (int h = 0; h < 2; h++) begin
      wr_cnt[h] = bus_we && (bus_addr == A_CNT0 + AW'(h));
      wr_prd[h] = bus_we && (bus_addr == A_PRD0 + AW'(h));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
      for (int h = 0; h < 2; h++) mode_q[h] <= EN_OFF;
    end else begin
      if (wr_gctl) gctl_q <= bus_wdata[GCTL_BITS-1:0];
      if (wr_ctrl) begin
        mode_q[0] <= en_mode_t'(bus_wdata[LO_EN_LSB +: 2]);
        mode_q[1] <= en_mode_t'(bus_wdata[HI_EN_LSB +: 2]);
      end else begin
        for (int h = 0; h < 2; h++)
          if (once_done[h]) mode_q[h] <= EN_OFF;
      end
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    dt_half #(.W(W)) u_half (
      .clk        (clk),
      .rst        (rst),
      .out_of_rst (gctl_q[h]),
      .count_ok   (count_ok),
      .mode       (mode_q[h]),
      .cnt_we     (wr_cnt[h]),
      .prd_we     (wr_prd[h]),
      .wdata      (bus_wdata),
      .cnt_q      (cnt_q[h]),
      .prd_q      (prd_q[h]),
      .cnt_d      (cnt_d[h]),
      .irq_q      (irq_h[h]),
      .once_done  (once_done[h])
    );
  end

  dt_cmp_bank #(.W(W), .N(NCMP), .IW(IW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we && in_cmp),
    .widx   (cmp_idx),
    .wdata  (bus_wdata),
    .ridx   (cmp_idx),
    .cnt_q  (cnt_q[0]),
    .cnt_d  (cnt_d[0]),
    .rd_val (cmp_rd),
    .irq_q  (irq_cmp)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[LO_EN_LSB +: 2] = mode_q[0];
    ctrl_view[HI_EN_LSB +: 2] = mode_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == A_CTRL)              bus_rdata <= ctrl_view;
      else if (bus_addr == A_GCTL)         bus_rdata <= W'(gctl_q);
      else if (bus_addr == A_CNT0)         bus_rdata <= cnt_q[0];
      else if (bus_addr == A_CNT0 + AW'(1)) bus_rdata <= cnt_q[1];
      else if (bus_addr == A_PRD0)         bus_rdata <= prd_q[0];
      else if (bus_addr == A_PRD0 + AW'(1)) bus_rdata <= prd_q[1];
      else if (in_cmp)                     bus_rdata <= cmp_rd;
    end
  end

  assign irq_lo = irq_h[0];
  assign irq_hi = irq_h[1];

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_ctrl,
  input logic         wr_cnt_lo,
  input logic [3:0]   gctl,
  input logic [1:0]   mode_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] prd_lo,
  input logic         irq_lo,
  input logic         irq_cmp
);

  logic active;
  assign active = gctl[0] && (gctl[3:2] == 2'd1);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && (mode_lo == 2'd1 || mode_lo == 2'd2) && cnt_lo != prd_lo && !wr_cnt_lo)
    |=> (cnt_lo == $past(cnt_lo) + W'(1))); // R3

  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !gctl[0] |=> (cnt_lo == '0)); // R4

  AST_LOOP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (active && mode_lo == 2'd2 && cnt_lo == prd_lo && !wr_cnt_lo)
    |=> (cnt_lo == '0 && irq_lo)); // R5

  AST_ONCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (active && mode_lo == 2'd1 && cnt_lo == prd_lo && !wr_cnt_lo && !wr_ctrl)
    |=> (mode_lo == 2'd0 && irq_lo && $stable(cnt_lo))); // R6

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (gctl[0] && (mode_lo == 2'd0 || mode_lo == 2'd3) && !wr_cnt_lo)
    |=> $stable(cnt_lo)); // R7

  AST_FOREIGN_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (gctl[0] && gctl[3:2] != 2'd1 && !wr_cnt_lo)
    |=> $stable(cnt_lo)); // R8

  AST_CMP_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    irq_cmp |-> (cnt_lo != $past(cnt_lo))); // R11

endmodule

bind dual_timer dt_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_ctrl   (wr_ctrl),
  .wr_cnt_lo (wr_cnt[0]),
  .gctl      (gctl_q),
  .mode_lo   (mode_q[0]),
  .cnt_lo    (cnt_q[0]),
  .prd_lo    (prd_q[0]),
  .irq_lo    (irq_lo),
  .irq_cmp   (irq_cmp)
);

// File: tb/test_dual_timer.sv
module test_dual_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi, irq_cmp;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dual_timer i_dual_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  localparam logic [3:0] CTRL = 4'd0, GCTL = 4'd1, CNTL = 4'd2, CNTH = 4'd3,
                         PRDL = 4'd4, PRDH = 4'd5;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int which, output int n);
    n = 0;
    while (n < 200 && !((which == 0) ? irq_lo : (which == 1) ? irq_hi : irq_cmp)) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_lo", 32'(irq_lo), 0);
    check("R1 irq_hi", 32'(irq_hi), 0);
    check("R1 irq_cmp", 32'(irq_cmp), 0);
    rd(CTRL, d); check("R1 ctrl", d, 0);
    rd(GCTL, d); check("R1 gctl", d, 0);
    rd(PRDL, d); check("R1 prd_lo", d, 0);
    rd(4'd12, d); check("R1 cmp4", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(PRDL, 32'hA5A5_1234); rd(PRDL, d); check("R2 prd_lo", d, 32'hA5A5_1234);
    wr(4'd15, 32'hDEAD_BEEF); rd(4'd15, d); check("R2 cmp7", d, 32'hDEAD_BEEF);
    wr(GCTL, 32'hFFFF_FFFF); rd(GCTL, d); check("R2 gctl bits", d, 32'h0000_000F);
    wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, d); check("R2 ctrl bits", d, 32'h00C0_00C0);
    rd(4'd6, d); check("R2 unused addr", d, 0);
    wr(CTRL, 0); wr(GCTL, 32'h7);
  endtask

  task automatic t_count_wrap;
    logic [31:0] d;
    wr(PRDL, 1000); wr(CNTL, 0);
    wr(CTRL, 32'(2) << 6);
    repeat (10) @(negedge clk);
    wr(CTRL, 0);
    rd(CNTL, d); check("R3 count rate", d, 11);
    wr(CNTL, 32'hFFFF_FFFE); rd(CNTL, d); check("R9 counter load", d, 32'hFFFF_FFFE);
    wr(CTRL, 32'(2) << 6);
    repeat (2) @(negedge clk);
    wr(CTRL, 0);
    rd(CNTL, d); check("R3 wrap", d, 1);
    repeat (5) @(negedge clk);
    rd(CNTL, d); check("R7 mode 0 holds", d, 1);
    wr(CTRL, 32'(3) << 6);
    repeat (5) @(negedge clk);
    rd(CNTL, d); check("R7 mode 3 holds", d, 1);
    wr(CTRL, 0);
  endtask

  task automatic t_hold_reset;
    logic [31:0] d;
    wr(GCTL, 32'h6);
    wr(CNTL, 55);
    wr(CTRL, 32'(2) << 6);
    repeat (5) @(negedge clk);
    rd(CNTL, d); check("R4 held at zero", d, 0);
    wr(CTRL, 0); wr(GCTL, 32'h7);
  endtask

  task automatic t_tmode;
    logic [31:0] d;
    wr(GCTL, 32'h3);
    wr(CNTL, 9);
    wr(CTRL, 32'(2) << 6);
    repeat (5) @(negedge clk);
    rd(CNTL, d); check("R8 mode 0 holds", d, 9);
    wr(GCTL, 32'hB);
    repeat (5) @(negedge clk);
    rd(CNTL, d); check("R8 mode 2 holds", d, 9);
    wr(CTRL, 0); wr(GCTL, 32'h7);
  endtask

  task automatic t_periodic;
    int n;
    wr(PRDL, 4); wr(CNTL, 0);
    wr(CTRL, 32'(2) << 6);
    wait_irq(0, n); check("R5 first irq delay", n, 5);
    @(negedge clk); check("R5 one-cycle pulse", 32'(irq_lo), 0);
    wait_irq(0, n); check("R5 irq spacing", n + 1, 5);
    wr(CTRL, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    int n, highs;
    wr(PRDL, 3); wr(CNTL, 0);
    wr(CTRL, 32'(1) << 6);
    wait_irq(0, n); check("R6 irq delay", n, 4);
    rd(CTRL, d); check("R6 mode cleared", d, 0);
    rd(CNTL, d); check("R6 counter at period", d, 3);
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq_lo) highs++;
    end
    check("R6 no second irq", highs, 0);
  endtask

  task automatic t_upper;
    logic [31:0] d;
    int n;
    wr(PRDH, 2); wr(CNTH, 0); wr(CNTL, 77);
    wr(CTRL, 32'(2) << 22);
    wait_irq(1, n); check("R12 upper irq delay", n, 3);
    check("R12 lower irq quiet", 32'(irq_lo), 0);
    rd(CNTL, d); check("R12 lower untouched", d, 77);
    wr(CTRL, 0);
  endtask

  task automatic t_compare;
    logic [31:0] d;
    int n, highs;
    wr(PRDL, 100); wr(CNTL, 0);
    wr(4'd8, 3); wr(4'd13, 7);
    wr(CTRL, 32'(2) << 6);
    wait_irq(2, n); check("R10 cmp0 match", n, 3);
    @(negedge clk); check("R10 cmp pulse ends", 32'(irq_cmp), 0);
    wait_irq(2, n); check("R10 cmp5 match", n + 1, 4);
    wr(4'd10, 2);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_cmp) highs++;
    end
    check("R11 passed value silent", highs, 0);
    wr(CTRL, 0);
    rd(CNTL, d);
    wr(4'd9, d);
    highs = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (irq_cmp) highs++;
    end
    check("R11 held value silent", highs, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count_wrap();
    t_hold_reset();
    t_tmode();
    t_periodic();
    t_oneshot();
    t_upper();
    t_compare();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule